// File: doc/BRIEF.md
# Clock Divider Parameter Search Engine

This block chooses the three integer settings of a clock synthesiser (an input prescale divider D, a feedback multiplier M and an output divider DOUT) so that `fin * M / D / DOUT` lands as close as possible to a requested output frequency. Both frequencies are given in kHz. Every candidate must keep two internal frequencies legal. The phase-comparison frequency `fin / D` must stay within 10,000 to 300,000 kHz. The oscillator frequency `fin * M / D` must stay within 600,000 to 1,200,000 kHz. When the search ends, each chosen integer is also turned into the high-count, low-count, odd-edge and bypass fields that a counter-based divider is loaded with.

The engine runs sequentially. All quotients come from one shared restoring divider that needs a fixed number of cycles per division. First the engine derives the D bounds and the M bounds. It then walks M upward. For each M it narrows the D range so that the oscillator frequency stays in its window, and it walks D upward inside that range. For each (M, D) pair it computes the oscillator frequency, rounds DOUT to the nearest integer, clamps DOUT, and scores the truncated achieved frequency.

States: `ST_IDLE` waits for a start pulse. `ST_DMIN`, `ST_DMAX`, `ST_MMIN` and `ST_MMAX` compute the four bounds, one division each, in that order. `ST_RANGE` goes to `ST_ENCODE` if either range is empty, and otherwise to `ST_NLO`. `ST_NLO` and `ST_NHI` narrow D for the current M. An empty narrowed range goes to the next M (`ST_NLO`), or to `ST_ENCODE` after the last M; a non-empty range goes to `ST_VCO`. `ST_VCO` goes to `ST_ROUND`, which goes to `ST_RATE`. `ST_RATE` scores the candidate and then goes to one of three places: `ST_ENCODE` on an exact hit or when both ranges are used up, `ST_VCO` for the next D, or `ST_NLO` for the next M. `ST_ENCODE` registers the results and goes to `ST_DONE`, which raises `done` for one cycle and returns to `ST_IDLE`. A start pulse with a zero frequency goes from `ST_IDLE` straight to `ST_ENCODE`.

Top module: `fsearch_engine`

## Requirements
- R1: Whenever `valid` is high with `done`, the reported D and M satisfy 10,000·D ≤ fin ≤ 300,000·D and 600,000·D ≤ fin·M ≤ 1,200,000·D, where fin is the value captured at the accepted start.
- R2: D bounds are max(⌈fin/300000⌉,1) through min(⌊fin/10000⌋,80). M bounds are max(⌈600000/fin⌉·Dlow,1) through min(⌊1200000·Dhigh/fin⌋,64). For each M, D is narrowed to max(Dlow,⌈fin·M/1200000⌉) through min(Dhigh,⌊fin·M/600000⌋).
- R3: DOUT is ⌊(fvco + ⌊fout/2⌋)/fout⌋, clamped to 1..128. The reported frequency `res_freq` is ⌊fvco/DOUT⌋, with fvco = ⌊fin·M/D⌋.
- R4: M is walked upward in the outer loop and D upward in the inner loop. The first legal candidate is always kept. A later candidate replaces the kept one only if its absolute error is strictly smaller, so on a tie the earliest candidate stays.
- R5: The search stops at the first candidate with zero error. With fin = fout = 100,000 kHz, `done` arrives within 300 cycles of the start pulse.
- R6: If no legal candidate exists, `valid` is 0 and `res_d`, `res_m`, `res_dout` and `res_freq` are all 0.
- R7: A start with `fin_khz` = 0 or `fout_khz` = 0 reports `valid` = 0 with all results 0.
- R8: For each result N, the encoding is high = ⌊N/2⌋, low = N − high, edge = N mod 2, and bypass = 1 only when N = 1. In `enc_high` and `enc_low`, slice 0 (bits 6:0) is D, slice 1 (bits 13:7) is M and slice 2 (bits 20:14) is DOUT. In `enc_edge` and `enc_nocnt`, bit 0 is D, bit 1 is M and bit 2 is DOUT.
- R9: `done` is high for exactly one cycle, after the results are registered. `busy` is high from the cycle after an accepted start until that `done` cycle, inclusive.
- R10: A start pulse while `busy` is high is ignored: the running search keeps its captured inputs and finishes with their result.
- R11: After reset, `busy`, `done` and `valid` are 0 and all results and encodings are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search; sampled only when idle |
| fin_khz | input | FREQ_W | Input reference frequency in kHz |
| fout_khz | input | FREQ_W | Requested output frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| valid | output | 1 | A legal candidate was found |
| res_d | output | NDIV_W | Chosen prescale divider |
| res_m | output | NDIV_W | Chosen feedback multiplier |
| res_dout | output | NDIV_W | Chosen output divider |
| res_freq | output | FREQ_W | Achieved output frequency in kHz |
| enc_high | output | 3·(NDIV_W−1) | High counts for D, M, DOUT |
| enc_low | output | 3·(NDIV_W−1) | Low counts for D, M, DOUT |
| enc_edge | output | 3 | Odd-edge bits for D, M, DOUT |
| enc_nocnt | output | 3 | Bypass bits for D, M, DOUT |

## Verification
Two things can fall into the same cycle. The first is a fresh start request and a search that is still running. The bench provokes this by pulsing `start` with different frequencies a few cycles into a run; it passes if `busy` stays high and the final result matches the first request's expected settings. The second is the exact-hit exit and the end-of-range exit, which both leave `ST_RATE`. The bench separates them with a vector that finds an exact hit on its very first candidate and must finish inside a short cycle bound. It contrasts this with vectors whose search runs to the last M, whose best candidates come from the bench's own model of the search.

// File: rtl/fsearch_pkg.sv
package fsearch_pkg;
    localparam int unsigned PFD_MIN_KHZ = 10000;
    localparam int unsigned PFD_MAX_KHZ = 300000;
    localparam int unsigned VCO_MIN_KHZ = 600000;
    localparam int unsigned VCO_MAX_KHZ = 1200000;
    localparam int unsigned D_CAP       = 80;
    localparam int unsigned M_CAP       = 64;
    localparam int unsigned DOUT_CAP    = 128;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DMIN, ST_DMAX, ST_MMIN, ST_MMAX, ST_RANGE,
        ST_NLO, ST_NHI, ST_VCO, ST_ROUND, ST_RATE, ST_ENCODE, ST_DONE
    } fs_state_e;
endpackage

// File: rtl/fsearch_divu.sv
module fsearch_divu #(
    parameter int W = 29
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quot
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem_q;
    logic [W-1:0]  quo_q, den_q;
    logic [CW-1:0] cnt_q;
    logic          run_q, done_q;
    logic [W:0]    trial;
    logic          fits;

    // shift the next numerator bit into the partial remainder
    always_comb begin
        trial = {rem_q[W-1:0], quo_q[W-1]};
        fits  = (trial >= {1'b0, den_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q <= '0;
                quo_q <= num;
                den_q <= den;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? (trial - {1'b0, den_q}) : trial;
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quot = quo_q;
endmodule

// File: rtl/fsearch_encode.sv
module fsearch_encode #(
    parameter int N_W = 8
) (
    input  logic [N_W-1:0] n,
    output logic [N_W-2:0] high,
    output logic [N_W-2:0] low,
    output logic           edge_bit,
    output logic           nocnt
);
    logic [N_W-1:0] half, rest;

    always_comb begin
        half     = n >> 1;
        rest     = n - half;
        high     = half[N_W-2:0];
        low      = rest[N_W-2:0];
        edge_bit = n[0];
        nocnt    = (n == N_W'(1));
    end
endmodule

// File: rtl/fsearch_engine.sv
module fsearch_engine
    import fsearch_pkg::*;
#(
    parameter int FREQ_W = 21,
    parameter int NDIV_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [FREQ_W-1:0]          fin_khz,
    input  logic [FREQ_W-1:0]          fout_khz,
    output logic                       busy,
    output logic                       done,
    output logic                       valid,
    output logic [NDIV_W-1:0]          res_d,
    output logic [NDIV_W-1:0]          res_m,
    output logic [NDIV_W-1:0]          res_dout,
    output logic [FREQ_W-1:0]          res_freq,
    output logic [3*(NDIV_W-1)-1:0]    enc_high,
    output logic [3*(NDIV_W-1)-1:0]    enc_low,
    output logic [2:0]                 enc_edge,
    output logic [2:0]                 enc_nocnt
);
    localparam int PROD_W = FREQ_W + NDIV_W;
    localparam int CNT_W  = NDIV_W - 1;
    localparam logic [PROD_W-1:0] K_PFD_MIN = PROD_W'(PFD_MIN_KHZ);
    localparam logic [PROD_W-1:0] K_PFD_MAX = PROD_W'(PFD_MAX_KHZ);
    localparam logic [PROD_W-1:0] K_VCO_MIN = PROD_W'(VCO_MIN_KHZ);
    localparam logic [PROD_W-1:0] K_VCO_MAX = PROD_W'(VCO_MAX_KHZ);
    localparam logic [PROD_W-1:0] K_NMAX    = PROD_W'(2**NDIV_W - 1);

    fs_state_e state_q, state_d;
    logic              issued_q, div_start, div_done, in_div;
    logic [PROD_W-1:0] div_num, div_den, div_q;
    logic [FREQ_W-1:0] fin_q, fout_q, best_f_q, best_err_q, rate_f, err;
    logic [PROD_W-1:0] fin_w, fout_w, fin_m, fvco_q, mm_prod;
    logic [NDIV_W-1:0] dmin_q, dmax_q, mmin_q, mmax_q, m_q, d_q, dend_q, dout_q;
    logic [NDIV_W-1:0] best_d_q, best_m_q, best_dout_q, q_sat, dend_next;
    logic              found_q, valid_q, better, rate_hit, last_d, last_m, nhi_empty;

    function automatic logic [NDIV_W-1:0] sat_n(input logic [PROD_W-1:0] v);
        return (v > K_NMAX) ? '1 : v[NDIV_W-1:0];
    endfunction

    // operand selection for the shared divider
    always_comb begin
        fin_w   = PROD_W'(fin_q);
        fout_w  = PROD_W'(fout_q);
        fin_m   = fin_w * PROD_W'(m_q);
        div_num = '0;
        div_den = '0;
        in_div  = 1'b1;
        unique case (state_q)
            ST_DMIN:  begin div_num = fin_w + K_PFD_MAX - 1'b1;  div_den = K_PFD_MAX; end
            ST_DMAX:  begin div_num = fin_w;                     div_den = K_PFD_MIN; end
            ST_MMIN:  begin div_num = K_VCO_MIN + fin_w - 1'b1;  div_den = fin_w;     end
            ST_MMAX:  begin div_num = K_VCO_MAX * PROD_W'(dmax_q); div_den = fin_w;   end
            ST_NLO:   begin div_num = fin_m + K_VCO_MAX - 1'b1;  div_den = K_VCO_MAX; end
            ST_NHI:   begin div_num = fin_m;                     div_den = K_VCO_MIN; end
            ST_VCO:   begin div_num = fin_m;                     div_den = PROD_W'(d_q); end
            ST_ROUND: begin div_num = fvco_q + (fout_w >> 1);    div_den = fout_w;    end
            ST_RATE:  begin div_num = fvco_q;                    div_den = PROD_W'(dout_q); end
            default:  in_div = 1'b0;
        endcase
        div_start = in_div && !issued_q;
    end

    fsearch_divu #(.W(PROD_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .num(div_num), .den(div_den), .done(div_done), .quot(div_q)
    );

    // decisions taken from the fresh quotient
    always_comb begin
        q_sat     = sat_n(div_q);
        mm_prod   = div_q * PROD_W'(dmin_q);
        dend_next = (q_sat < dmax_q) ? q_sat : dmax_q;
        nhi_empty = d_q > dend_next;
        rate_f    = div_q[FREQ_W-1:0];
        err       = (rate_f > fout_q) ? (rate_f - fout_q) : (fout_q - rate_f);
        rate_hit  = (err == '0);
        better    = !found_q || (err < best_err_q);
        last_d    = d_q >= dend_q;
        last_m    = m_q >= mmax_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = (fin_khz == '0 || fout_khz == '0) ? ST_ENCODE : ST_DMIN;
            ST_DMIN:   if (div_done) state_d = ST_DMAX;
            ST_DMAX:   if (div_done) state_d = ST_MMIN;
            ST_MMIN:   if (div_done) state_d = ST_MMAX;
            ST_MMAX:   if (div_done) state_d = ST_RANGE;
            ST_RANGE:  state_d = (dmin_q > dmax_q || mmin_q > mmax_q) ? ST_ENCODE : ST_NLO;
            ST_NLO:    if (div_done) state_d = ST_NHI;
            ST_NHI:    if (div_done) state_d = !nhi_empty ? ST_VCO : (last_m ? ST_ENCODE : ST_NLO);
            ST_VCO:    if (div_done) state_d = ST_ROUND;
            ST_ROUND:  if (div_done) state_d = ST_RATE;
            ST_RATE:   if (div_done) state_d = rate_hit ? ST_ENCODE : (!last_d ? ST_VCO :
                                               (!last_m ? ST_NLO : ST_ENCODE));
            ST_ENCODE: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issued_q <= 1'b0;
            {fin_q, fout_q, best_f_q, best_err_q, res_freq} <= '0;
            {dmin_q, dmax_q, mmin_q, mmax_q, m_q, d_q, dend_q, dout_q} <= '0;
            {best_d_q, best_m_q, best_dout_q, res_d, res_m, res_dout} <= '0;
            fvco_q  <= '0;
            found_q <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            if (div_start)     issued_q <= 1'b1;
            else if (div_done) issued_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    fin_q   <= fin_khz;
                    fout_q  <= fout_khz;
                    found_q <= 1'b0;
                end
                ST_DMIN: if (div_done) dmin_q <= (div_q == '0) ? NDIV_W'(1) : q_sat;
                ST_DMAX: if (div_done) dmax_q <= (q_sat > NDIV_W'(D_CAP)) ? NDIV_W'(D_CAP) : q_sat;
                ST_MMIN: if (div_done)
                    mmin_q <= (mm_prod > PROD_W'(M_CAP)) ? NDIV_W'(M_CAP + 1) :
                              ((mm_prod == '0) ? NDIV_W'(1) : mm_prod[NDIV_W-1:0]);
                ST_MMAX: if (div_done) mmax_q <= (q_sat > NDIV_W'(M_CAP)) ? NDIV_W'(M_CAP) : q_sat;
                ST_RANGE: m_q <= mmin_q;
                ST_NLO:  if (div_done) d_q <= (q_sat > dmin_q) ? q_sat : dmin_q;
                ST_NHI:  if (div_done) begin
                    dend_q <= dend_next;
                    if (nhi_empty) m_q <= m_q + 1'b1;
                end
                ST_VCO:   if (div_done) fvco_q <= div_q;
                ST_ROUND: if (div_done)
                    dout_q <= (div_q == '0) ? NDIV_W'(1) :
                              ((div_q > PROD_W'(DOUT_CAP)) ? NDIV_W'(DOUT_CAP) : div_q[NDIV_W-1:0]);
                ST_RATE: if (div_done) begin
                    if (better) begin
                        found_q     <= 1'b1;
                        best_err_q  <= err;
                        best_f_q    <= rate_f;
                        best_d_q    <= d_q;
                        best_m_q    <= m_q;
                        best_dout_q <= dout_q;
                    end
                    if (!rate_hit && !last_d)     d_q <= d_q + 1'b1;
                    else if (!rate_hit && last_d) m_q <= m_q + 1'b1;
                end
                ST_ENCODE: begin
                    valid_q  <= found_q;
                    res_d    <= found_q ? best_d_q    : '0;
                    res_m    <= found_q ? best_m_q    : '0;
                    res_dout <= found_q ? best_dout_q : '0;
                    res_freq <= found_q ? best_f_q    : '0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy  = (state_q != ST_IDLE);
        done  = (state_q == ST_DONE);
        valid = valid_q;
    end

    logic [2:0][NDIV_W-1:0] enc_src;
    assign enc_src = {res_dout, res_m, res_d};

    for (genvar gi = 0; gi < 3; gi++) begin : g_enc
        fsearch_encode #(.N_W(NDIV_W)) u_enc (
            .n(enc_src[gi]),
            .high(enc_high[gi*CNT_W +: CNT_W]),
            .low(enc_low[gi*CNT_W +: CNT_W]),
            .edge_bit(enc_edge[gi]),
            .nocnt(enc_nocnt[gi])
        );
    end
endmodule

// File: rtl/fsearch_engine_chk.sv
module fsearch_engine_chk
    import fsearch_pkg::*;
#(
    parameter int FREQ_W = 21,
    parameter int NDIV_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic [FREQ_W-1:0]       fin_khz,
    input logic                    busy,
    input logic                    done,
    input logic                    valid,
    input logic [NDIV_W-1:0]       res_d,
    input logic [NDIV_W-1:0]       res_m,
    input logic [NDIV_W-1:0]       res_dout,
    input logic [FREQ_W-1:0]       res_freq,
    input logic [3*(NDIV_W-1)-1:0] enc_high,
    input logic [3*(NDIV_W-1)-1:0] enc_low
);
    localparam int CNT_W = NDIV_W - 1;

    logic [FREQ_W-1:0] fin_lat;
    logic [63:0] d64, fin64, fvco_num;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              fin_lat <= '0;
        else if (start && !busy) fin_lat <= fin_khz;
    end

    assign d64      = 64'(res_d);
    assign fin64    = 64'(fin_lat);
    assign fvco_num = fin64 * 64'(res_m);

    p_pfd_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done && valid |-> (d64 * 64'(PFD_MIN_KHZ) <= fin64) && (fin64 <= d64 * 64'(PFD_MAX_KHZ)));

    p_vco_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done && valid |-> (d64 * 64'(VCO_MIN_KHZ) <= fvco_num) && (fvco_num <= d64 * 64'(VCO_MAX_KHZ)));

    p_limits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done && valid |-> res_d >= 1 && res_d <= NDIV_W'(D_CAP) && res_m >= 1 && res_m <= NDIV_W'(M_CAP));

    p_dout_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done && valid |-> res_dout >= 1 && res_dout <= NDIV_W'(DOUT_CAP));

    p_none_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !valid |-> res_d == '0 && res_m == '0 && res_dout == '0 && res_freq == '0);

    p_enc_sum_d_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> NDIV_W'(enc_high[CNT_W-1:0]) + NDIV_W'(enc_low[CNT_W-1:0]) == res_d);

    p_enc_sum_dout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> NDIV_W'(enc_high[2*CNT_W +: CNT_W]) + NDIV_W'(enc_low[2*CNT_W +: CNT_W]) == res_dout);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);

    p_start_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind fsearch_engine fsearch_engine_chk #(.FREQ_W(FREQ_W), .NDIV_W(NDIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .fin_khz(fin_khz), .busy(busy),
    .done(done), .valid(valid), .res_d(res_d), .res_m(res_m), .res_dout(res_dout),
    .res_freq(res_freq), .enc_high(enc_high), .enc_low(enc_low)
);

// File: tb/fsearch_engine_tb.sv
module fsearch_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FREQ_W     = 21;
    localparam int NDIV_W     = 8;
    localparam int CNT_W      = NDIV_W - 1;
    localparam int RUN_LIMIT  = 60000;
    localparam int NVEC       = 6;
    // stimulus: fin, fout; expected valid flag; values come from ref_search
    localparam longint VEC_FIN  [NVEC] = '{100000, 125000, 1000000, 100000, 100000, 5000};
    localparam longint VEC_FOUT [NVEC] = '{100000, 25000,  250000,  148500, 1000,   1000};
    localparam bit     VEC_VALID[NVEC] = '{1, 1, 1, 1, 1, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [FREQ_W-1:0] fin_khz = '0, fout_khz = '0;
    logic busy, done, valid;
    logic [NDIV_W-1:0] res_d, res_m, res_dout;
    logic [FREQ_W-1:0] res_freq;
    logic [3*CNT_W-1:0] enc_high, enc_low;
    logic [2:0] enc_edge, enc_nocnt;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsearch_engine #(.FREQ_W(FREQ_W), .NDIV_W(NDIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .fin_khz(fin_khz), .fout_khz(fout_khz),
        .busy(busy), .done(done), .valid(valid), .res_d(res_d), .res_m(res_m),
        .res_dout(res_dout), .res_freq(res_freq), .enc_high(enc_high), .enc_low(enc_low),
        .enc_edge(enc_edge), .enc_nocnt(enc_nocnt)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_eq(input string tag, input longint act, input longint exp);
        check(act == exp, tag, act, exp);
    endtask

    // independent model of the search, written from the requirements
    task automatic ref_search(input longint fi, input longint fo,
                              output longint ed, output longint em,
                              output longint edo, output longint ef);
        longint dmin, dmax, mmin, mmax, lo, hi, fv, dv, ff, e, be;
        bit fnd = 0, stop = 0;
        ed = 0; em = 0; edo = 0; ef = 0; be = 0;
        if (fi == 0 || fo == 0) return;
        dmin = (fi + 299999) / 300000;     if (dmin < 1) dmin = 1;
        dmax = fi / 10000;                 if (dmax > 80) dmax = 80;
        mmin = ((600000 + fi - 1) / fi) * dmin; if (mmin < 1) mmin = 1;
        mmax = 1200000 * dmax / fi;        if (mmax > 64) mmax = 64;
        for (longint m = mmin; m <= mmax && !stop; m++) begin
            lo = (fi * m + 1199999) / 1200000; if (lo < dmin) lo = dmin;
            hi = fi * m / 600000;              if (hi > dmax) hi = dmax;
            for (longint dd = lo; dd <= hi && !stop; dd++) begin
                fv = fi * m / dd;
                dv = (fv + fo / 2) / fo;
                if (dv < 1) dv = 1;
                if (dv > 128) dv = 128;
                ff = fv / dv;
                e  = (ff > fo) ? ff - fo : fo - ff;
                if (!fnd || e < be) begin
                    fnd = 1; be = e; ed = dd; em = m; edo = dv; ef = ff;
                end
                if (e == 0) stop = 1;
            end
        end
    endtask

    task automatic run_case(input longint fi, input longint fo, output int cycles);
        @(negedge clk);
        fin_khz  = FREQ_W'(fi);
        fout_khz = FREQ_W'(fo);
        start    = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        cycles = 1;
        while (!done && cycles < RUN_LIMIT) begin
            @(negedge clk);
            cycles++;
        end
        if (!done) check(1'b0, "R9 done never arrived", cycles, RUN_LIMIT);
    endtask

    task automatic check_enc(input int idx, input longint n, input string what);
        longint hi_e = n / 2;
        check_eq({"R8 high ", what}, longint'(enc_high[idx*CNT_W +: CNT_W]), hi_e);
        check_eq({"R8 low ", what},  longint'(enc_low[idx*CNT_W +: CNT_W]), n - hi_e);
        check_eq({"R8 edge ", what}, longint'(enc_edge[idx]), n % 2);
        check_eq({"R8 nocnt ", what}, longint'(enc_nocnt[idx]), (n == 1) ? 1 : 0);
    endtask

    task automatic check_result(input longint ed, input longint em, input longint edo,
                                input longint ef, input bit ev);
        check_eq("R4 res_d", longint'(res_d), ed);
        check_eq("R4 res_m", longint'(res_m), em);
        check_eq("R3 res_dout", longint'(res_dout), edo);
        check_eq("R3 res_freq", longint'(res_freq), ef);
        check_eq("R6 valid", longint'(valid), longint'(ev));
        check_enc(0, ed, "D");
        check_enc(1, em, "M");
        check_enc(2, edo, "DOUT");
    endtask

    initial begin
        #(longint'(CLK_PERIOD) * 190000);
        check(1'b0, "R9 watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        int cyc;
        longint ed, em, edo, ef;

        repeat (3) @(negedge clk);
        // R11 reset state
        check_eq("R11 busy after reset", longint'(busy), 0);
        check_eq("R11 done after reset", longint'(done), 0);
        check_eq("R11 valid after reset", longint'(valid), 0);
        check_eq("R11 results after reset", longint'({res_d, res_m, res_dout, res_freq}), 0);
        check_eq("R11 encodings after reset", longint'({enc_high, enc_low, enc_edge, enc_nocnt}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // stimulus table walked by one loop
        for (int i = 0; i < NVEC; i++) begin
            ref_search(VEC_FIN[i], VEC_FOUT[i], ed, em, edo, ef);
            run_case(VEC_FIN[i], VEC_FOUT[i], cyc);
            check_eq("R6 table valid flag", longint'(valid), longint'(VEC_VALID[i]));
            check_result(ed, em, edo, ef, VEC_VALID[i]);
            @(negedge clk);
            check_eq("R9 done single cycle", longint'(done), 0);
            check_eq("R9 busy released", longint'(busy), 0);
        end

        // R5 exact hit on the first candidate ends early: D1 M6 DOUT6
        run_case(100000, 100000, cyc);
        check(cyc <= 300, "R5 early stop cycles", cyc, 300);
        check_eq("R5 d", longint'(res_d), 1);
        check_eq("R5 m", longint'(res_m), 6);
        check_eq("R5 dout", longint'(res_dout), 6);

        // R3 odd DOUT: 125000 -> 25000 gives DOUT 25
        run_case(125000, 25000, cyc);
        check_eq("R3 dout 25", longint'(res_dout), 25);
        check_eq("R8 dout high 12", longint'(enc_high[2*CNT_W +: CNT_W]), 12);
        check_eq("R8 dout low 13", longint'(enc_low[2*CNT_W +: CNT_W]), 13);

        // R3 clamp and R4 tie: lowest fvco 600000 / 128, earliest M6 D1 kept
        run_case(100000, 1000, cyc);
        check_eq("R3 dout clamped", longint'(res_dout), 128);
        check_eq("R3 truncated freq", longint'(res_freq), 4687);
        check_eq("R4 tie keeps first m", longint'(res_m), 6);
        check_eq("R4 tie keeps first d", longint'(res_d), 1);

        // R7 zero inputs
        run_case(0, 100000, cyc);
        check_eq("R7 zero fin valid", longint'(valid), 0);
        check_eq("R7 zero fin results", longint'({res_d, res_m, res_dout, res_freq}), 0);
        run_case(100000, 0, cyc);
        check_eq("R7 zero fout valid", longint'(valid), 0);
        check_eq("R7 zero fout results", longint'({res_d, res_m, res_dout, res_freq}), 0);

        // R10 second start while busy is ignored
        @(negedge clk);
        fin_khz = FREQ_W'(100000); fout_khz = FREQ_W'(100000); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        check_eq("R9 busy during run", longint'(busy), 1);
        fin_khz = FREQ_W'(200000); fout_khz = FREQ_W'(74250); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R10 still busy after extra start", longint'(busy), 1);
        cyc = 0;
        while (!done && cyc < RUN_LIMIT) begin @(negedge clk); cyc++; end
        check_eq("R10 result d", longint'(res_d), 1);
        check_eq("R10 result m", longint'(res_m), 6);
        check_eq("R10 result dout", longint'(res_dout), 6);
        check_eq("R10 result freq", longint'(res_freq), 100000);
        check_eq("R1 valid on legal result", longint'(valid), 1);
        @(negedge clk);
        check_eq("R10 no second run", longint'(busy), 0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule